// File: doc/BRIEF.md
# I2C SCL Timing and Bus-Recovery Front End

This block produces the serial clock for an I2C peripheral and gives software a way to recover a hung bus. A 10-bit divisor N sets the clock: the generator pulls SCL low for N+10 system clocks, then releases it for N+10 system clocks. With a 12 MHz system clock this gives a line rate of 12 MHz / (2·(N+10)), so N = 0x032 gives 100 kHz. Software should keep N at 0x032 or above to stay within standard-mode speed, but every 10-bit value produces a clean waveform. If a slave holds SCL low when the generator releases it, the release phase is extended until the line is seen high.

A one-bit recovery control forces SCL low while it holds 0. The block holds this forced-low state in every operating mode. While the recovery control is active, the block also tells the surrounding controller to fall back to slave-receiver mode. A forced reset leaves the divisor setting as it was. A read-only status word shows the SDA and SCL levels after a two-flop synchronizer.

The three registers are reached through a small 16-bit register port at byte offsets 0, 2 and 4. Reads are combinational from the offset. Writes take effect on the clock edge where select and write are both high. SCL is driven open-drain: `scl_oe` high means pull the line low.

Top module: `scl_timing_ctrl`

## Requirements
- R1: The clock-select register at offset 0 stores N in bits 9:0. Bits 15:10 read as 0. It resets to 0x0000.
- R2: The recovery-control register at offset 2 stores one bit in bit 0 and resets to 0x0001. Bits 15:1 read as 0. Offsets are decoded from address bits 2:1, and address bit 0 is ignored.
- R3: The status register at offset 4 reads SDA in bit 1 and SCL in bit 0, each after two synchronizer flops. A line change made between two rising edges appears after the second of the two following rising edges. All other bits read 0. It reads 0x0000 in reset, and writes to it change nothing.
- R4: Take the case where `gen_en` is 1, the recovery bit is 1 and no slave stretches the clock. Then `scl_oe` alternates between a pull-low phase and a release phase, and each phase lasts exactly N+10 clocks.
- R5: R4 holds for every N from 0x000 to 0x3FF, including 0 (phases of 10 clocks) and 0x3FF (phases of 1033 clocks).
- R6: While the recovery bit is 0, `scl_oe` and `slave_rx_force` are both 1, whatever `gen_en` is. This holds from the cycle after the write.
- R7: A forced reset, while it is active and after it is released, leaves the clock-select value unchanged.
- R8: Writing the recovery bit back to 1 with `gen_en` high releases `scl_oe` from the next cycle. The first pull-low then comes after N+10 released clocks.
- R9: While the generator releases SCL but the synchronized SCL is still 0, the release phase does not end. Once the pin goes high, `scl_oe` returns to 1 on the third rising edge after the change, counted from the moment the pin changes.
- R10: With `gen_en` low and the recovery bit 1, `scl_oe` is 0 at once. When `gen_en` rises again, the generator starts with a release phase.
- R11: A register access with `bus_sel` low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, used with bus_sel |
| bus_addr | input | 3 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| gen_en | input | 1 | Controller requests master clocking |
| scl_in | input | 1 | Sensed SCL pin level |
| sda_in | input | 1 | Sensed SDA pin level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| slave_rx_force | output | 1 | Hold controller in slave-receiver mode |

## Verification
Two functions can fall in the same cycle: the generator reaching the end of a phase, and a recovery write or a slave stretch landing on that same cycle. The bench places recovery writes at random offsets into a running clock with random divisors. In each case it checks three things: that SCL is held low, that the divisor reads back intact, and that after release the first phase has full length. A separate run holds the pin low across a phase end and checks the exact edge on which the pull-low resumes once the pin rises.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    localparam int REG_BITS  = 16;
    localparam int DIV_BITS  = 10;
    localparam int DIV_BIAS  = 10;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        SEL_DIV  = 2'd0,
        SEL_RCV  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } scl_phase_e;

    typedef struct packed {
        logic sda;
        logic scl;
    } line_pair_t;

    function automatic reg_sel_e decode_offset(input logic [1:0] word_idx);
        case (word_idx)
            2'd0:    return SEL_DIV;
            2'd1:    return SEL_RCV;
            2'd2:    return SEL_STAT;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic scl_phase_e flip_phase(input scl_phase_e p);
        return (p == PH_HIGH) ? PH_LOW : PH_HIGH;
    endfunction

endpackage

// File: rtl/scl_regfile.sv
module scl_regfile
    import scl_timing_pkg::*;
#(
    parameter int DIV_W = DIV_BITS,
    parameter int REG_W = REG_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [REG_W-1:0] wdata,
    input  line_pair_t       status,
    output logic [DIV_W-1:0] div_q,
    output logic             rcv_q,
    output logic [REG_W-1:0] rdata
);

    // Register state: divisor resets to zero, recovery bit resets released.
    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            rcv_q <= 1'b1;
        end else if (wr_en) begin
            case (sel)
                SEL_DIV: div_q <= wdata[DIV_W-1:0];
                SEL_RCV: rcv_q <= wdata[0];
                default: ;
            endcase
        end
    end

    // Read mux; unused bit positions stay zero.
    always_comb begin
        rdata = '0;
        case (sel)
            SEL_DIV:  rdata[DIV_W-1:0] = div_q;
            SEL_RCV:  rdata[0]         = rcv_q;
            SEL_STAT: rdata[1:0]       = {status.sda, status.scl};
            default:  rdata            = '0;
        endcase
    end

    logic unused_wdata_bits;
    assign unused_wdata_bits = ^wdata[REG_W-1:DIV_W];

endmodule

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] synced
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[STAGES-2:0], raw[i]};
        end
        assign synced[i] = chain[STAGES-1];
    end

endmodule

// File: rtl/scl_divider.sv
module scl_divider
    import scl_timing_pkg::*;
#(
    parameter int DIV_W  = DIV_BITS,
    parameter int OFFSET = DIV_BIAS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_n,
    input  logic             run_req,
    input  logic             bus_ok,
    input  logic             scl_seen,
    output logic             scl_oe
);

    localparam int CNT_W = DIV_W + 1;

    scl_phase_e       phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload;
    logic             running;
    logic             at_end;
    logic             stretched;

    // Each phase spans N+OFFSET clocks: counter runs reload..0.
    assign reload    = CNT_W'(div_n) + CNT_W'(OFFSET - 1);
    assign running   = run_req & bus_ok;
    assign at_end    = (cnt_q == '0);
    assign stretched = (phase_q == PH_HIGH) & ~scl_seen;

    always_ff @(posedge clk) begin
        if (rst || !running) begin
            phase_q <= PH_HIGH;
            cnt_q   <= reload;
        end else if (at_end) begin
            if (!stretched) begin
                phase_q <= flip_phase(phase_q);
                cnt_q   <= reload;
            end
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Open-drain: forced recovery always pulls; otherwise only in low phase.
    assign scl_oe = ~bus_ok | (running & (phase_q == PH_LOW));

endmodule

// File: rtl/scl_timing_ctrl.sv
module scl_timing_ctrl
    import scl_timing_pkg::*;
#(
    parameter int DIV_W       = DIV_BITS,
    parameter int DIV_OFFSET  = DIV_BIAS,
    parameter int SYNC_STAGES = SYNC_DEPTH
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [2:0]          bus_addr,
    input  logic [REG_BITS-1:0] bus_wdata,
    output logic [REG_BITS-1:0] bus_rdata,
    input  logic                gen_en,
    input  logic                scl_in,
    input  logic                sda_in,
    output logic                scl_oe,
    output logic                slave_rx_force
);

    reg_sel_e         sel;
    logic             wr_en;
    logic [DIV_W-1:0] div_q;
    logic             rcv_q;
    logic [1:0]       sync_lines;
    line_pair_t       status;

    assign sel   = decode_offset(bus_addr[2:1]);
    assign wr_en = bus_sel & bus_wr;

    assign status.sda = sync_lines[1];
    assign status.scl = sync_lines[0];

    scl_regfile #(.DIV_W(DIV_W), .REG_W(REG_BITS)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .sel    (sel),
        .wdata  (bus_wdata),
        .status (status),
        .div_q  (div_q),
        .rcv_q  (rcv_q),
        .rdata  (bus_rdata)
    );

    scl_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw    ({sda_in, scl_in}),
        .synced (sync_lines)
    );

    scl_divider #(.DIV_W(DIV_W), .OFFSET(DIV_OFFSET)) u_div (
        .clk      (clk),
        .rst      (rst),
        .div_n    (div_q),
        .run_req  (gen_en),
        .bus_ok   (rcv_q),
        .scl_seen (status.scl),
        .scl_oe   (scl_oe)
    );

    assign slave_rx_force = ~rcv_q;

    logic unused_addr_lsb;
    assign unused_addr_lsb = bus_addr[0];

endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk #(
    parameter int DIV_W = 10,
    parameter int REG_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [2:0]       bus_addr,
    input logic [REG_W-1:0] bus_rdata,
    input logic             gen_en,
    input logic             scl_oe,
    input logic             slave_rx_force,
    input logic             rcv_bit,
    input logic [DIV_W-1:0] div_val,
    input logic             scl_seen
);

    assert_clksel_upper_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[2:1] == 2'd0) |-> ((bus_rdata >> DIV_W) == '0));

    assert_rcv_upper_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[2:1] == 2'd1) |-> (bus_rdata[REG_W-1:1] == '0));

    assert_status_upper_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[2:1] == 2'd2) |-> (bus_rdata[REG_W-1:2] == '0));

    assert_forced_pull_R6: assert property (@(posedge clk) disable iff (rst)
        !rcv_bit |-> (scl_oe && slave_rx_force));

    assert_div_kept_R7: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && bus_wr && bus_addr[2:1] == 2'd0) |=> $stable(div_val));

    assert_stretch_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (rcv_bit && gen_en && !scl_oe && !scl_seen) |=> (!scl_oe || !rcv_bit));

    assert_idle_release_R10: assert property (@(posedge clk) disable iff (rst)
        (rcv_bit && !gen_en) |-> !scl_oe);

    logic unused_chk_lsb;
    assign unused_chk_lsb = bus_addr[0];

endmodule

bind scl_timing_ctrl scl_timing_chk #(.DIV_W(DIV_W), .REG_W(16)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_sel        (bus_sel),
    .bus_wr         (bus_wr),
    .bus_addr       (bus_addr),
    .bus_rdata      (bus_rdata),
    .gen_en         (gen_en),
    .scl_oe         (scl_oe),
    .slave_rx_force (slave_rx_force),
    .rcv_bit        (rcv_q),
    .div_val        (div_q),
    .scl_seen       (sync_lines[0])
);

// File: tb/sim_scl_timing_ctrl.sv
module sim_scl_timing_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int BIAS       = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        gen_en = 1'b0;
    logic        scl_in;
    logic        sda_in;
    logic        scl_oe;
    logic        slave_rx_force;
    logic        tb_scl_low = 1'b0;
    logic        tb_sda = 1'b1;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Open-drain line model: low if the block or a stretching slave pulls.
    assign scl_in = ~scl_oe & ~tb_scl_low;
    assign sda_in = tb_sda;

    scl_timing_ctrl u0 (
        .clk            (clk),
        .rst            (rst),
        .bus_sel        (bus_sel),
        .bus_wr         (bus_wr),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .gen_en         (gen_en),
        .scl_in         (scl_in),
        .sda_in         (sda_in),
        .scl_oe         (scl_oe),
        .slave_rx_force (slave_rx_force)
    );

    function automatic logic [15:0] exp_div(input logic [15:0] w);
        return w & 16'h03FF;
    endfunction

    function automatic logic [15:0] exp_rcv(input logic [15:0] w);
        return {15'h0, w[0]};
    endfunction

    function automatic logic [15:0] exp_status(input logic sda, input logic scl);
        return {14'h0, sda, scl};
    endfunction

    function automatic int exp_phase(input int n);
        return n + BIAS;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d, input logic sel);
        @(negedge clk);
        bus_sel = sel; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic measure(output int lo, output int hi);
        do @(negedge clk); while (scl_oe !== 1'b0);
        do @(negedge clk); while (scl_oe !== 1'b1);
        lo = 0;
        while (scl_oe === 1'b1) begin lo++; @(negedge clk); end
        hi = 0;
        while (scl_oe === 1'b0) begin hi++; @(negedge clk); end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        int lo, hi;
        void'($urandom(32'd20240517));

        repeat (4) @(negedge clk);
        rst = 1'b0;
        // Reset state, before any active edge after reset.
        bus_read(3'd0, rd); check("R1 reset", rd, 16'h0000);
        bus_read(3'd2, rd); check("R2 reset", rd, 16'h0001);
        bus_read(3'd4, rd); check("R3 reset", rd, 16'h0000);
        check("R10 reset idle", scl_oe, 1'b0);
        check("R6 reset no force", slave_rx_force, 1'b0);

        // R1 / R11: random divisor writes, unselected writes ignored.
        for (int i = 0; i < 10; i++) begin
            logic [15:0] w;
            w = 16'($urandom);
            bus_write(3'd0, w, 1'b1);
            bus_read(3'd0, rd); check("R1 write", rd, exp_div(w));
            bus_write(3'd0, ~w, 1'b0);
            bus_read(3'd0, rd); check("R11 unselected", rd, exp_div(w));
        end
        bus_write(3'd2, 16'h0000, 1'b0);
        bus_read(3'd2, rd); check("R11 rcv unselected", rd, 16'h0001);
        check("R11 scl_oe", scl_oe, 1'b0);

        // R2: recovery bit, odd address alias.
        bus_write(3'd3, 16'hFFFE, 1'b1);
        bus_read(3'd2, rd); check("R2 bit0 clear", rd, exp_rcv(16'hFFFE));
        check("R6 force idle", scl_oe, 1'b1);
        check("R6 slave rx", slave_rx_force, 1'b1);
        bus_write(3'd2, 16'hFFFF, 1'b1);
        bus_read(3'd2, rd); check("R2 bit0 set", rd, exp_rcv(16'hFFFF));

        // R3: synchronized line status, two-edge latency, writes ignored.
        begin
            logic psda, pscl;
            psda = tb_sda; pscl = 1'b1;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                tb_sda = i[0]; tb_scl_low = i[1];
                @(negedge clk);
                bus_read(3'd4, rd); check("R3 one edge", rd, exp_status(psda, pscl));
                @(negedge clk);
                bus_read(3'd4, rd); check("R3 two edges", rd, exp_status(i[0], ~i[1]));
                psda = i[0]; pscl = ~i[1];
            end
            tb_scl_low = 1'b0; tb_sda = 1'b1;
            repeat (3) @(negedge clk);
            bus_write(3'd4, 16'h0000, 1'b1);
            bus_read(3'd4, rd); check("R3 write ignored", rd, exp_status(1'b1, 1'b1));
            bus_read(3'd0, rd); check("R3 write no side effect", rd[15:10], 6'h0);
        end

        // R4 / R5: phase lengths over divisor corners and random values.
        for (int i = 0; i < 8; i++) begin
            int n;
            case (i)
                0: n = 0;
                1: n = 1;
                2: n = 'h32;
                3: n = 'h3FF;
                default: n = int'($urandom_range(0, 120));
            endcase
            gen_en = 1'b0;
            bus_write(3'd0, 16'(n), 1'b1);
            gen_en = 1'b1;
            measure(lo, hi);
            check((i < 4) ? "R5 low phase" : "R4 low phase", lo, exp_phase(n));
            check((i < 4) ? "R5 high phase" : "R4 high phase", hi, exp_phase(n));
        end

        // R10: dropping gen_en releases SCL at once.
        do @(negedge clk); while (scl_oe !== 1'b1);
        gen_en = 1'b0;
        #1; check("R10 release", scl_oe, 1'b0);
        @(negedge clk); check("R10 stays released", scl_oe, 1'b0);

        // R9: slave stretch across the end of the release phase.
        bus_write(3'd0, 16'd5, 1'b1);
        gen_en = 1'b1;
        do @(negedge clk); while (scl_oe !== 1'b0);
        do @(negedge clk); while (scl_oe !== 1'b1);
        tb_scl_low = 1'b1;
        do @(negedge clk); while (scl_oe !== 1'b0);
        begin
            bit held;
            held = 1'b1;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (scl_oe !== 1'b0) held = 1'b0;
            end
            check("R9 stretch hold", held, 1'b1);
        end
        tb_scl_low = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 still released", scl_oe, 1'b0);
        @(negedge clk);
        check("R9 resume pull", scl_oe, 1'b1);

        // R6 / R7 / R8: recovery writes at random points of a running clock.
        for (int i = 0; i < 12; i++) begin
            int n;
            bit held;
            n = int'($urandom_range(0, 40));
            bus_write(3'd0, 16'(n), 1'b1);
            gen_en = 1'b1;
            repeat ($urandom_range(0, 80)) @(negedge clk);
            bus_write(3'd2, 16'h0000, 1'b1);
            check("R6 forced low", scl_oe, 1'b1);
            check("R6 slave rx", slave_rx_force, 1'b1);
            held = 1'b1;
            repeat ($urandom_range(1, 20)) begin
                @(negedge clk);
                if (scl_oe !== 1'b1) held = 1'b0;
            end
            gen_en = i[0];
            @(negedge clk);
            if (scl_oe !== 1'b1) held = 1'b0;
            check("R6 hold any gen_en", held, 1'b1);
            bus_read(3'd0, rd); check("R7 divisor kept", rd, 16'(n));
            gen_en = 1'b1;
            bus_write(3'd2, 16'h0001, 1'b1);
            check("R8 slave rx off", slave_rx_force, 1'b0);
            check("R8 released", scl_oe, 1'b0);
            hi = 0;
            while (scl_oe === 1'b0) begin hi++; @(negedge clk); end
            check("R8 first release", hi, exp_phase(n));
            bus_read(3'd0, rd); check("R7 after release", rd, 16'(n));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule